// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This controller connects a clocked host to an external asynchronous static RAM built from four byte-wide banks. The four banks share one address bus and one active-low output enable. Each bank has its own active-low chip select and its own active-low write enable. The host issues one access at a time over a request/ready handshake. The controller then creates the memory-side strobes, spacing them with cycle counters whose lengths are parameters. Each length is the memory's timing figure divided by the clock period and rounded up.

A per-request width setting makes the same memory look 32, 16 or 8 bits wide. In the narrow modes, the lowest one or two host address bits choose which lanes are enabled. On a write, the host data is copied onto every lane, so the chosen lane receives it. On a read, the chosen lane's data is shifted down and zero-extended. Write data leaves the chip through a drive value and a separate drive-enable output, for use by a tri-state pad. After a read, that drive stays off for a turnaround gap, so the memory has time to release the bus.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is active and on leaving it, all chip selects, all write enables and the output enable are high, the data drive enable is low and ready is high.
- R2: Ready is high only when no access is in progress. A request is taken on a clock edge where request and ready are both high. Ready returns high SETUP_CYC+WR_STROBE_CYC+HOLD_CYC cycles after a write is taken, and SETUP_CYC+RD_STROBE_CYC+HOLD_CYC cycles after a read is taken.
- R3: Width code 0 (32-bit) drives host address bits [18:0] onto the memory address and selects all four lanes. Lane n carries data bits [8n+7:8n].
- R4: Width code 1 (16-bit) drives host address bits [19:1] onto the memory address. Host bit 0 equal to 0 selects lanes 0 and 1, and equal to 1 selects lanes 2 and 3. Write data bits [15:0] appear on both halves. A read returns the chosen half zero-extended. Lanes that are not selected keep their contents.
- R5: Width code 2 (8-bit) drives host address bits [20:2] onto the memory address. Host bits [1:0] name the single lane used. Write data bits [7:0] appear on every lane. A read returns that lane zero-extended, and the other lanes keep their contents.
- R6: A write holds the write enables of the selected lanes low for exactly WR_STROBE_CYC cycles, with the output enable high. Write enables never go low on a lane whose chip select is high.
- R7: A read holds the output enable low for RD_STROBE_CYC cycles with every write enable high. The data is captured on the last strobe cycle and given with exactly one valid pulse per read. A write gives no valid pulse.
- R8: A write taken after a read waits TURN_CYC extra cycles before driving the bus, and drives it no sooner than TURN_CYC cycles after the output enable rose. A write following a write has no such wait.
- R9: The data drive is never enabled while the output enable is low. The memory address does not change while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| width_i | input | 2 | Access width: 0 = 32, 1 = 16, 2 = 8 bits |
| addr_i | input | 21 | Host address, counted in units of the access width |
| wdata_i | input | 32 | Write data, right-aligned in narrow modes |
| ready_o | output | 1 | Controller idle and able to take a request |
| rdata_o | output | 32 | Read data, right-aligned and zero-extended |
| rvalid_o | output | 1 | One-cycle pulse marking valid read data |
| mem_addr_o | output | 19 | Memory address |
| mem_cs_n_o | output | 4 | Per-lane chip selects, active low |
| mem_we_n_o | output | 4 | Per-lane write enables, active low |
| mem_oe_n_o | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 32 | Data returned by the memory |

## Verification
The assertions check the following on every cycle:
- the bus is never driven while the output enable is low;
- a write enable is never low outside its chip select, and never low together with the output enable;
- no chip select is low while idle;
- three lanes are never selected at once;
- the address stays stable during an access;
- a valid pulse lasts one cycle;
- the drive never starts while a turnaround is still owed.

Only the bench scenarios show that data lands in the right lanes and comes back correctly shifted, that narrow writes leave neighbouring lanes unchanged, that strobe lengths and access latencies are exact, and that the turnaround wait appears only when a write follows a read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    WIDTH_32 = 2'd0,
    WIDTH_16 = 2'd1,
    WIDTH_8  = 2'd2
  } width_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_ctrl_pkg::*;
#(
  parameter int MEM_AW = 19,
  parameter int LANE_W = 8
) (
  input  width_e                  width,
  input  logic [MEM_AW+1:0]       haddr,
  input  logic [4*LANE_W-1:0]     wdata,
  output logic [MEM_AW-1:0]       maddr,
  output logic [3:0]              lane_en,
  output logic [1:0]              lane_sel,
  output logic [4*LANE_W-1:0]     wsteer
);
  always_comb begin
    case (width)
      WIDTH_16: begin
        maddr    = haddr[MEM_AW:1];
        lane_en  = haddr[0] ? 4'b1100 : 4'b0011;
        lane_sel = {haddr[0], 1'b0};
        wsteer   = {2{wdata[2*LANE_W-1:0]}};
      end
      WIDTH_8: begin
        maddr    = haddr[MEM_AW+1:2];
        lane_en  = 4'b0001 << haddr[1:0];
        lane_sel = haddr[1:0];
        wsteer   = {4{wdata[LANE_W-1:0]}};
      end
      default: begin
        maddr    = haddr[MEM_AW-1:0];
        lane_en  = 4'b1111;
        lane_sel = 2'd0;
        wsteer   = wdata;
      end
    endcase
  end
endmodule

// File: rtl/sram_rd_align.sv
module sram_rd_align
  import sram_ctrl_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  width_e              width,
  input  logic [1:0]          lane_sel,
  input  logic [4*LANE_W-1:0] raw,
  output logic [4*LANE_W-1:0] aligned
);
  localparam int DW = 4 * LANE_W;

  logic [LANE_W-1:0] lane_byte [4];

  for (genvar g = 0; g < 4; g++) begin : g_split
    assign lane_byte[g] = raw[g*LANE_W +: LANE_W];
  end

  always_comb begin
    case (width)
      WIDTH_16: aligned = {{(DW-2*LANE_W){1'b0}},
                           lane_sel[1] ? {lane_byte[3], lane_byte[2]}
                                       : {lane_byte[1], lane_byte[0]}};
      WIDTH_8:  aligned = {{(DW-LANE_W){1'b0}}, lane_byte[lane_sel]};
      default:  aligned = raw;
    endcase
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC     = 1,
  parameter int WR_STROBE_CYC = 5,
  parameter int RD_STROBE_CYC = 7,
  parameter int HOLD_CYC      = 1,
  parameter int TURN_CYC      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       we,
  input  logic [3:0] lane_en,
  output logic       ready,
  output logic       accept,
  output logic       capture,
  output logic [3:0] cs_n,
  output logic [3:0] we_n,
  output logic       oe_n,
  output logic       dq_oe
);
  localparam int M1    = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int M2    = (WR_STROBE_CYC > RD_STROBE_CYC) ? WR_STROBE_CYC : RD_STROBE_CYC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M3 > TURN_CYC) ? M3 : TURN_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] L_WR    = CNT_W'(WR_STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] L_RD    = CNT_W'(RD_STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] L_TURN  = CNT_W'(TURN_CYC - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             op_we_q, op_we_d;
  logic [3:0]       lanes_q, lanes_d;
  logic             dirty_q, dirty_d;
  logic [3:0]       cs_n_d, we_n_d;
  logic             oe_n_d, dq_oe_d;
  logic             last;

  assign ready   = (ph_q == PH_IDLE);
  assign accept  = ready && req;
  assign last    = (cnt_q == '0);
  assign capture = (ph_q == PH_STROBE) && !op_we_q && last;
  assign op_we_d = accept ? we : op_we_q;
  assign lanes_d = accept ? lane_en : lanes_q;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    dirty_d = dirty_q;
    case (ph_q)
      PH_IDLE: if (accept) begin
        if (we && dirty_q) begin
          ph_d  = PH_TURN;
          cnt_d = L_TURN;
        end else begin
          ph_d  = PH_SETUP;
          cnt_d = L_SETUP;
        end
      end
      PH_TURN: if (last) begin
        ph_d    = PH_SETUP;
        cnt_d   = L_SETUP;
        dirty_d = 1'b0;
      end
      PH_SETUP: if (last) begin
        ph_d  = PH_STROBE;
        cnt_d = op_we_q ? L_WR : L_RD;
      end
      PH_STROBE: if (last) begin
        ph_d  = PH_HOLD;
        cnt_d = L_HOLD;
        if (!op_we_q) dirty_d = 1'b1;
      end
      PH_HOLD: if (last) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    cs_n_d  = 4'hF;
    we_n_d  = 4'hF;
    oe_n_d  = 1'b1;
    dq_oe_d = 1'b0;
    if (ph_d == PH_SETUP || ph_d == PH_STROBE) begin
      cs_n_d  = ~lanes_d;
      dq_oe_d = op_we_d;
    end
    if (ph_d == PH_STROBE) begin
      if (op_we_d) we_n_d = ~lanes_d;
      else         oe_n_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      op_we_q <= 1'b0;
      lanes_q <= '0;
      dirty_q <= 1'b0;
      cs_n    <= 4'hF;
      we_n    <= 4'hF;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      op_we_q <= op_we_d;
      lanes_q <= lanes_d;
      dirty_q <= dirty_d;
      cs_n    <= cs_n_d;
      we_n    <= we_n_d;
      oe_n    <= oe_n_d;
      dq_oe   <= dq_oe_d;
    end
  end

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));
  // R6
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~we_n) & cs_n) == 4'h0);
  // R7
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n == 4'hF));
  // R2
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs_n == 4'hF && dq_oe == 1'b0));
  // R8
  turn_paid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> !dirty_q);
  // R3
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) != 3);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int MEM_AW        = 19,
  parameter int LANE_W        = 8,
  parameter int SETUP_CYC     = 1,
  parameter int WR_STROBE_CYC = 5,
  parameter int RD_STROBE_CYC = 7,
  parameter int HOLD_CYC      = 1,
  parameter int TURN_CYC      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [1:0]            width_i,
  input  logic [MEM_AW+1:0]     addr_i,
  input  logic [4*LANE_W-1:0]   wdata_i,
  output logic                  ready_o,
  output logic [4*LANE_W-1:0]   rdata_o,
  output logic                  rvalid_o,
  output logic [MEM_AW-1:0]     mem_addr_o,
  output logic [3:0]            mem_cs_n_o,
  output logic [3:0]            mem_we_n_o,
  output logic                  mem_oe_n_o,
  output logic [4*LANE_W-1:0]   mem_dq_o,
  output logic                  mem_dq_oe_o,
  input  logic [4*LANE_W-1:0]   mem_dq_i
);
  localparam int DW = 4 * LANE_W;

  logic [1:0]        rst_sync;
  logic              rst_n_int;
  logic              accept, capture;
  logic [MEM_AW-1:0] maddr_d;
  logic [3:0]        lane_en_d;
  logic [1:0]        sel_d, sel_q;
  logic [DW-1:0]     wsteer_d, wdata_q, aligned;
  width_e            width_q;
  logic [DW-1:0]     rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  sram_lane_map #(.MEM_AW(MEM_AW), .LANE_W(LANE_W)) i_map (
    .width(width_e'(width_i)), .haddr(addr_i), .wdata(wdata_i),
    .maddr(maddr_d), .lane_en(lane_en_d), .lane_sel(sel_d), .wsteer(wsteer_d)
  );

  sram_seq #(
    .SETUP_CYC(SETUP_CYC), .WR_STROBE_CYC(WR_STROBE_CYC),
    .RD_STROBE_CYC(RD_STROBE_CYC), .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_CYC)
  ) i_seq (
    .clk(clk), .rst_n(rst_n_int), .req(req_i), .we(we_i), .lane_en(lane_en_d),
    .ready(ready_o), .accept(accept), .capture(capture),
    .cs_n(mem_cs_n_o), .we_n(mem_we_n_o), .oe_n(mem_oe_n_o), .dq_oe(mem_dq_oe_o)
  );

  sram_rd_align #(.LANE_W(LANE_W)) i_align (
    .width(width_q), .lane_sel(sel_q), .raw(mem_dq_i), .aligned(aligned)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mem_addr_o <= '0;
      wdata_q    <= '0;
      width_q    <= WIDTH_32;
      sel_q      <= '0;
    end else if (accept) begin
      mem_addr_o <= maddr_d;
      wdata_q    <= wsteer_d;
      width_q    <= width_e'(width_i);
      sel_q      <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= aligned;
    end
  end

  assign mem_dq_o = wdata_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R7
  rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    rvalid_o |=> !rvalid_o);
  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!ready_o && $past(!ready_o)) |-> $stable(mem_addr_o));
endmodule

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
  localparam int SETUP_CYC = 1, WR_CYC = 5, RD_CYC = 7, HOLD_CYC = 1, TURN_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  width_i = 2'd0;
  logic [20:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ready_o, rvalid_o, mem_oe_n_o, mem_dq_oe_o;
  logic [31:0] rdata_o, mem_dq_o, mem_dq_i;
  logic [18:0] mem_addr_o;
  logic [3:0]  mem_cs_n_o, mem_we_n_o;

  int pass_cnt = 0, total_cnt = 0;
  bit done = 0;
  bit last_read = 0;

  logic [7:0] model_mem [256][4];
  logic [7:0] ref_mem   [256][4];
  int         we_run = 0, last_we_len = 0, since_oe = 1000, last_gap = 0;
  bit         prev_dq_oe = 0, conflict_seen = 0;
  logic [3:0] rd_cs;
  logic [18:0] rd_addr;

  always #5 clk = ~clk;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .width_i(width_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .mem_addr_o(mem_addr_o), .mem_cs_n_o(mem_cs_n_o),
    .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  // memory model: returns a filler byte on lanes not being read
  always_comb begin
    for (int l = 0; l < 4; l++)
      mem_dq_i[l*8 +: 8] = (!mem_oe_n_o && !mem_cs_n_o[l]) ? model_mem[mem_addr_o[7:0]][l] : 8'hA5;
  end

  always @(negedge clk) begin
    if (mem_dq_oe_o && !mem_oe_n_o) conflict_seen = 1;
    if (mem_dq_oe_o && !prev_dq_oe) last_gap = since_oe;
    prev_dq_oe = mem_dq_oe_o;
    if (!mem_oe_n_o) begin
      since_oe = 0; rd_cs = mem_cs_n_o; rd_addr = mem_addr_o;
    end else if (since_oe < 1000) since_oe++;
    if (mem_we_n_o != 4'hF) begin
      we_run++;
      for (int l = 0; l < 4; l++)
        if (!mem_cs_n_o[l] && !mem_we_n_o[l] && mem_dq_oe_o)
          model_mem[mem_addr_o[7:0]][l] = mem_dq_o[l*8 +: 8];
    end else if (we_run > 0) begin
      last_we_len = we_run; we_run = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total_cnt++;
    if (ok) pass_cnt++;
    else $display("FAIL %s actual=%h expected=%h", rq, act, exp);
  endtask

  function automatic logic [18:0] exp_maddr(input logic [1:0] w, input logic [20:0] a);
    case (w)
      2'd1: return a[19:1];
      2'd2: return a[20:2];
      default: return a[18:0];
    endcase
  endfunction

  function automatic logic [3:0] exp_lanes(input logic [1:0] w, input logic [20:0] a);
    case (w)
      2'd1: return a[0] ? 4'b1100 : 4'b0011;
      2'd2: return 4'b0001 << a[1:0];
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] w, input logic [20:0] a);
    logic [7:0]  m;
    logic [31:0] r;
    m = exp_maddr(w, a)[7:0];
    r = {ref_mem[m][3], ref_mem[m][2], ref_mem[m][1], ref_mem[m][0]};
    case (w)
      2'd1: return a[0] ? {16'h0, r[31:16]} : {16'h0, r[15:0]};
      2'd2: return {24'h0, r[a[1:0]*8 +: 8]};
      default: return r;
    endcase
  endfunction

  task automatic ref_write(input logic [1:0] w, input logic [20:0] a, input logic [31:0] d);
    logic [7:0] m;
    logic [3:0] ln;
    m  = exp_maddr(w, a)[7:0];
    ln = exp_lanes(w, a);
    for (int l = 0; l < 4; l++)
      if (ln[l]) begin
        case (w)
          2'd1: ref_mem[m][l] = d[(l%2)*8 +: 8];
          2'd2: ref_mem[m][l] = d[7:0];
          default: ref_mem[m][l] = d[l*8 +: 8];
        endcase
      end
  endtask

  task automatic do_op(input bit wr, input logic [1:0] w, input logic [20:0] a, input logic [31:0] d);
    int lat = 0, rv = 0, exp_lat;
    logic [31:0] got = '0;
    bit was_read = last_read;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req_i = 1; we_i = wr; width_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0;
    while (!ready_o) begin
      lat++;
      if (rvalid_o) begin rv++; got = rdata_o; end
      @(negedge clk);
    end
    if (wr) begin
      ref_write(w, a, d);
      exp_lat = SETUP_CYC + WR_CYC + HOLD_CYC + (was_read ? TURN_CYC : 0);
      chk(lat == exp_lat, was_read ? "R8 write latency after read" : "R2 write latency", lat, exp_lat);
      chk(last_we_len == WR_CYC, "R6 write strobe length", last_we_len, WR_CYC);
      chk(last_gap >= TURN_CYC, "R8 bus turnaround gap", last_gap, TURN_CYC);
      chk(rv == 0, "R7 no valid pulse on write", rv, 0);
      last_read = 0;
    end else begin
      exp_lat = SETUP_CYC + RD_CYC + HOLD_CYC;
      chk(lat == exp_lat, "R2 read latency", lat, exp_lat);
      chk(rv == 1, "R7 one valid pulse", rv, 1);
      chk(got == exp_read(w, a), w == 2'd0 ? "R3 read data" : (w == 2'd1 ? "R4 read data" : "R5 read data"),
          got, exp_read(w, a));
      chk(rd_cs == ~exp_lanes(w, a), "R3 lane selects on read", rd_cs, ~exp_lanes(w, a));
      chk(rd_addr == exp_maddr(w, a), "R3 memory address", rd_addr, exp_maddr(w, a));
      last_read = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total_cnt++;
      $display("FAIL R2 watchdog actual=busy expected=finished");
      $display("%0d/%0d checks passed", pass_cnt, total_cnt);
      $finish;
    end
  end

  initial begin
    logic [1:0]  w;
    logic [20:0] a;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++)
      for (int l = 0; l < 4; l++) begin model_mem[i][l] = 8'h00; ref_mem[i][l] = 8'h00; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n_o == 4'hF && mem_we_n_o == 4'hF, "R1 strobes high in reset", {mem_cs_n_o, mem_we_n_o}, 8'hFF);
    chk(mem_oe_n_o == 1'b1 && mem_dq_oe_o == 1'b0, "R1 oe high, no drive in reset", {mem_oe_n_o, mem_dq_oe_o}, 2'b10);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1 && mem_cs_n_o == 4'hF, "R1 idle after reset", {ready_o, mem_cs_n_o}, 5'h1F);

    // R3 full-width write and read
    do_op(1, 2'd0, 21'h10, 32'h11223344);
    do_op(0, 2'd0, 21'h10, 32'h0);
    // R8 write after read pays turnaround, write after write does not
    do_op(1, 2'd0, 21'h11, 32'hCAFEF00D);
    do_op(1, 2'd0, 21'h12, 32'h01020304);
    // R4 half write leaves other half intact
    do_op(1, 2'd1, {20'h10, 1'b1}, 32'h0000BEEF);
    do_op(0, 2'd0, 21'h10, 32'h0);
    chk(exp_read(2'd0, 21'h10) == 32'hBEEF3344, "R4 other half kept", exp_read(2'd0, 21'h10), 32'hBEEF3344);
    do_op(0, 2'd1, {20'h10, 1'b0}, 32'h0);
    do_op(0, 2'd1, {20'h10, 1'b1}, 32'h0);
    // R5 byte write to lane 2 and reads
    do_op(1, 2'd2, {19'h11, 2'd2}, 32'hFFFFFF5A);
    do_op(0, 2'd0, 21'h11, 32'h0);
    chk(exp_read(2'd0, 21'h11) == 32'hCA5AF00D, "R5 other lanes kept", exp_read(2'd0, 21'h11), 32'hCA5AF00D);
    do_op(0, 2'd2, {19'h11, 2'd2}, 32'h0);
    do_op(0, 2'd2, {19'h11, 2'd3}, 32'h0);

    for (int n = 0; n < 400; n++) begin
      w = 2'($urandom_range(0, 2));
      case (w)
        2'd1: a = {16'h0, 4'($urandom_range(0, 15)), 1'($urandom)};
        2'd2: a = {15'h0, 4'($urandom_range(0, 15)), 2'($urandom)};
        default: a = {17'h0, 4'($urandom_range(0, 15))};
      endcase
      do_op(1'($urandom), w, a, $urandom);
    end

    chk(conflict_seen == 0, "R9 no drive while output enabled", 32'(conflict_seen), 0);
    done = 1;
    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end
endmodule